// File: doc/BRIEF.md
# Adaptive Synchronous Rectifier Gate Timer

This block controls the gate of one synchronous-rectifier switch. Its input `sense_on` is an already-digitised, clock-synchronous comparator result. It is 1 while the switch's drain-source voltage sits under the detection threshold, which in practice means while the body diode or channel is conducting.

The block rejects short pulses on that input. It switches the gate on a fixed number of clock cycles after a conduction interval begins, and it measures how long each interval lasts. It does not wait for the present interval's input to fall. Instead, it removes the gate drive early, at a point predicted from the interval it measured one switching cycle before, shortened by a programmable dead time. A deasserted sample while the gate is on still forces the gate off at once. The latest measured length is exposed as a plain status value.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `sr_gate_timer`

## Requirements
- R1: A conduction interval starts only after `sense_on` has been sampled 1 on DEB_CYC (default 15) consecutive clock edges. A shorter run of 1s leaves `gate` at 0 and `meas_len` unchanged.
- R2: The gate cannot turn on before ON_CYC = DEB_CYC + PROP_CYC (default 35) asserted samples have been counted from the first sample of the interval. The first cycle with `gate` high follows the edge that samples the 35th asserted input.
- R3: The measured length is the number of samples from the first asserted sample of an interval up to its last asserted sample. This last asserted sample is the one just before a run of DEB_CYC deasserted samples ends the interval. The length appears on `meas_len` the cycle after that ending run completes, and it is held until the next interval ends.
- R4: During an interval, a deasserted sample drives `gate` to 0 in the following cycle, and the gate stays 0 until a new interval starts.
- R5: When the previous interval measured P cycles, the gate is high only while the elapsed sample count n satisfies ON_CYC <= n < P - `dead_cyc`. `dead_cyc` is captured when the interval starts.
- R6: If P - `dead_cyc` <= ON_CYC, the gate stays 0 for the whole interval, but the interval is still measured.
- R7: In the first interval after reset there is no previous measurement. In that interval `gate` stays 0 and only the measurement is taken.
- R8: A deasserted glitch that lasts fewer than DEB_CYC samples does not end the interval. Its samples count toward the measured length.
- R9: The length counter saturates at 2^LEN_W - 1 (default 4095) and does not wrap.
- R10: While reset is held, and in the first cycle after it, `gate` is 0 and `meas_len` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sense_on | input | 1 | 1 while the sensed drain-source voltage is under threshold |
| dead_cyc | input | DEAD_W | Dead time in cycles subtracted from the previous length |
| gate | output | 1 | Gate command for the rectifier switch |
| meas_len | output | LEN_W | Last measured conduction length in cycles |

## Verification
The first interval after reset is driven with a plain 100-cycle assertion, so that measurement can be told apart from drive. A second, identical interval then shows the predicted turn-off point and the 35-cycle turn-on point. A large dead time separates the "prediction too short" case from normal drive. Further patterns each target one behaviour: a sub-debounce pulse checks filtering, a 5-cycle mid-interval glitch checks that the measurement continues while the gate is killed, an interval shorter than its prediction checks the early forced turn-off, and a 4200-cycle interval checks saturation.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_COND = 1'b1} phase_e;
endpackage

// File: rtl/sr_edge_filter.sv
module sr_edge_filter
  import sr_gate_pkg::*;
#(
  parameter int DEB_CYC = 15
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sense_on,
  input  phase_e phase,
  output logic   start_hit,
  output logic   end_hit
);
  localparam int RUN_W = $clog2(DEB_CYC + 1);
  localparam logic [RUN_W-1:0] LAST_RUN = RUN_W'(DEB_CYC - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(DEB_CYC);

  logic [RUN_W-1:0] on_run, off_run;

  assign start_hit = (phase == PH_IDLE) && sense_on  && (on_run  == LAST_RUN);
  assign end_hit   = (phase == PH_COND) && !sense_on && (off_run == LAST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_run  <= '0;
      off_run <= '0;
    end else if (phase == PH_IDLE) begin
      off_run <= '0;
      if (!sense_on || start_hit) on_run <= '0;
      else if (on_run != RUN_MAX) on_run <= on_run + 1'b1;
    end else begin
      on_run <= '0;
      if (sense_on || end_hit) off_run <= '0;
      else if (off_run != RUN_MAX) off_run <= off_run + 1'b1;
    end
  end

  generate
    if (DEB_CYC > 1) begin : g_chk
      // R1: a start needs the previous sample asserted as well
      a_r1_start_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |-> $past(sense_on));
    end
  endgenerate
endmodule

// File: rtl/sr_cond_meter.sv
module sr_cond_meter
  import sr_gate_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int DEB_CYC = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sense_on,
  input  logic             start_hit,
  input  logic             end_hit,
  output phase_e           phase,
  output logic [LEN_W-1:0] elapsed,
  output logic [LEN_W-1:0] last_len,
  output logic             meas_ok
);
  localparam logic [LEN_W-1:0] LEN_MAX   = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] DEB_COUNT = LEN_W'(DEB_CYC);

  logic [LEN_W-1:0] run_len;
  logic [LEN_W-1:0] elapsed_inc;

  assign elapsed_inc = (elapsed == LEN_MAX) ? LEN_MAX : elapsed + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      elapsed  <= '0;
      run_len  <= '0;
      last_len <= '0;
      meas_ok  <= 1'b0;
    end else if (start_hit) begin
      phase   <= PH_COND;
      elapsed <= DEB_COUNT;
      run_len <= DEB_COUNT;
    end else if (end_hit) begin
      phase    <= PH_IDLE;
      last_len <= run_len;
      meas_ok  <= 1'b1;
    end else if (phase == PH_COND) begin
      elapsed <= elapsed_inc;
      if (sense_on) run_len <= elapsed_inc;
    end
  end

  // R9: the elapsed count holds at its ceiling
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COND && !end_hit && elapsed == LEN_MAX) |=> elapsed == LEN_MAX);
  // R3: the published length only moves when an interval ends
  a_r3_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COND && !end_hit) |=> $stable(last_len));
endmodule

// File: rtl/sr_gate_sched.sv
module sr_gate_sched
  import sr_gate_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int DEAD_W  = 8,
  parameter int DEB_CYC = 15,
  parameter int PROP_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sense_on,
  input  logic              start_hit,
  input  phase_e            phase,
  input  logic [LEN_W-1:0]  elapsed,
  input  logic [LEN_W-1:0]  last_len,
  input  logic              meas_ok,
  input  logic [DEAD_W-1:0] dead_cyc,
  output logic              gate
);
  localparam logic [LEN_W-1:0] ON_CYC = LEN_W'(DEB_CYC + PROP_CYC);

  logic [LEN_W-1:0] dead_ext, off_pred, off_lim;
  logic             armed, killed, pred_ok;

  assign dead_ext = LEN_W'(dead_cyc);
  assign off_pred = last_len - dead_ext;
  assign pred_ok  = meas_ok && (last_len > dead_ext) && (off_pred > ON_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      killed  <= 1'b0;
      off_lim <= '0;
    end else if (start_hit) begin
      armed   <= pred_ok;
      killed  <= 1'b0;
      off_lim <= off_pred;
    end else if (phase == PH_COND && !sense_on) begin
      killed <= 1'b1;
    end
  end

  assign gate = (phase == PH_COND) && armed && !killed &&
                (elapsed >= ON_CYC) && (elapsed < off_lim);

  // R4: a deasserted sample during conduction removes the gate next cycle
  a_r4_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COND && !sense_on) |=> !gate);
  // R7: no drive without an earlier measurement
  a_r7_needs_meas: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> meas_ok);
  // R2: the gate rises exactly at the turn-on count
  a_r2_rise_point: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> elapsed == ON_CYC);
endmodule

// File: rtl/sr_gate_timer.sv
module sr_gate_timer
  import sr_gate_pkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int DEAD_W   = 8,
  parameter int DEB_CYC  = 15,
  parameter int PROP_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sense_on,
  input  logic [DEAD_W-1:0] dead_cyc,
  output logic              gate,
  output logic [LEN_W-1:0]  meas_len
);
  phase_e           phase;
  logic             start_hit, end_hit, meas_ok;
  logic [LEN_W-1:0] elapsed;

  sr_edge_filter #(.DEB_CYC(DEB_CYC)) u_filter (
    .clk(clk), .rst_n(rst_n), .sense_on(sense_on), .phase(phase),
    .start_hit(start_hit), .end_hit(end_hit)
  );

  sr_cond_meter #(.LEN_W(LEN_W), .DEB_CYC(DEB_CYC)) u_meter (
    .clk(clk), .rst_n(rst_n), .sense_on(sense_on),
    .start_hit(start_hit), .end_hit(end_hit),
    .phase(phase), .elapsed(elapsed), .last_len(meas_len), .meas_ok(meas_ok)
  );

  sr_gate_sched #(.LEN_W(LEN_W), .DEAD_W(DEAD_W), .DEB_CYC(DEB_CYC),
                  .PROP_CYC(PROP_CYC)) u_sched (
    .clk(clk), .rst_n(rst_n), .sense_on(sense_on), .start_hit(start_hit),
    .phase(phase), .elapsed(elapsed), .last_len(meas_len), .meas_ok(meas_ok),
    .dead_cyc(dead_cyc), .gate(gate)
  );
endmodule

// File: tb/sr_gate_timer_bench.sv
`timescale 1ns/1ps
module sr_gate_timer_bench;
  localparam int LEN_W = 12, DEAD_W = 8, DEB = 15, PROP = 20;
  localparam int ON = DEB + PROP;
  localparam int LMAX = (1 << LEN_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, sense_on = 1'b0;
  logic [DEAD_W-1:0] dead_cyc = '0;
  logic gate;
  logic [LEN_W-1:0] meas_len;

  always #5 clk = ~clk;

  sr_gate_timer #(.LEN_W(LEN_W), .DEAD_W(DEAD_W), .DEB_CYC(DEB), .PROP_CYC(PROP))
    u_sr_gate_timer (.clk(clk), .rst_n(rst_n), .sense_on(sense_on),
                     .dead_cyc(dead_cyc), .gate(gate), .meas_len(meas_len));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference model
  bit m_act, m_pv, m_kill, m_arm, m_gate;
  int m_on, m_off, m_n, m_len, m_p, m_offl;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_pv = 0; m_kill = 0; m_arm = 0; m_gate = 0;
      m_on = 0; m_off = 0; m_n = 0; m_len = 0; m_p = 0; m_offl = 0;
    end else begin
      if (!m_act) begin
        if (sense_on) begin
          m_on++;
          if (m_on >= DEB) begin
            m_act = 1; m_n = DEB; m_len = DEB; m_kill = 0; m_on = 0; m_off = 0;
            m_offl = m_p - int'(dead_cyc);
            m_arm = m_pv && (m_offl > ON);
          end
        end else m_on = 0;
      end else begin
        m_n = (m_n + 1 > LMAX) ? LMAX : m_n + 1;
        if (sense_on) begin m_off = 0; m_len = m_n; end
        else begin
          m_kill = 1; m_off++;
          if (m_off >= DEB) begin m_act = 0; m_p = m_len; m_pv = 1; m_off = 0; end
        end
      end
      m_gate = m_act && m_arm && !m_kill && m_n >= ON && m_n < m_offl;
    end
  end

  // per-cycle comparison, plus gate counters for the scenario checks
  int gcnt = 0, low_edges = 0, rise_at = -1;
  always @(posedge clk) low_edges <= sense_on ? low_edges + 1 : 0;
  always @(negedge clk) if (rst_n && !done) begin
    n_cmp++;
    if (gate !== m_gate) begin
      n_bad++;
      $display("FAIL R5 per-cycle gate: actual %0b expected %0b at %0t", gate, m_gate, $time);
    end
    n_cmp++;
    if (meas_len !== LEN_W'(m_p)) begin
      n_bad++;
      $display("FAIL R3 per-cycle meas_len: actual %0d expected %0d at %0t", meas_len, m_p, $time);
    end
    if (gate) begin
      gcnt++;
      if (rise_at < 0) rise_at = low_edges;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      sense_on = v;
    end
  endtask

  task automatic pulse(input int lo);
    gcnt = 0; rise_at = -1;
    drive(1'b1, lo);
    drive(1'b0, 25);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(gate == 0, "R10 reset gate", gate, 0);
    chk(meas_len == 0, "R10 reset meas_len", meas_len, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(gate == 0 && meas_len == 0, "R10 after reset", meas_len, 0);

    dead_cyc = 8'd10;
    pulse(100);
    chk(gcnt == 0, "R7 first interval gate cycles", gcnt, 0);
    chk(meas_len == 100, "R3 first length", meas_len, 100);

    pulse(100);
    chk(gcnt == 55, "R5 gate cycles with dead 10", gcnt, 55);
    chk(rise_at == ON, "R2 turn-on count", rise_at, ON);

    dead_cyc = 8'd65;
    pulse(100);
    chk(gcnt == 0, "R6 short prediction gate cycles", gcnt, 0);
    chk(meas_len == 100, "R6 still measured", meas_len, 100);

    dead_cyc = 8'd10;
    pulse(10);
    chk(gcnt == 0, "R1 short run gate", gcnt, 0);
    chk(meas_len == 100, "R1 short run length", meas_len, 100);

    gcnt = 0;
    drive(1'b1, 80); drive(1'b0, 5); drive(1'b1, 40); drive(1'b0, 25);
    chk(meas_len == 125, "R8 glitch length", meas_len, 125);
    chk(gcnt == 46, "R4 glitch kills gate", gcnt, 46);

    pulse(60);
    chk(gcnt == 26, "R4 early end forced off", gcnt, 26);
    chk(meas_len == 60, "R3 second length", meas_len, 60);

    pulse(4200);
    chk(meas_len == LMAX, "R9 saturated length", meas_len, LMAX);

    pulse(100);
    chk(gcnt == 66, "R5 drive after saturation", gcnt, 66);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule